// File: doc/BRIEF.md
# Serial Debug Frame to Bus Master Bridge

This block sits behind a test access port on the bus-access debug chain. While the TAP is in its shift state it collects a serial frame holding a bus address, a direction bit, a data word and an 8-bit checksum. When the TAP updates, the block checks the frame's length and checksum. A good frame becomes one classic single-word bus cycle, issued in the system clock domain.

A read does not return its word in the same scan. The returned word is held, and the next scan's capture loads it into the shift register so that it leaves on `tdo`. A status bit next to it tells whether the last access ended with a bus error. Requests and completions cross between the scan clock and the system clock through toggle handshakes, each synchronised by two flip-flops. Both resets assert asynchronously and are released in step with their own clock.

Top module: `jtag_bus_bridge`

## Requirements
- R1: After reset `bus_cyc_o` and `bus_stb_o` are low and `tdo` is 0.
- R2: The frame enters LSB first: ADDR_W address bits (frame bits 0..31 by default), then the direction bit (bit 32, 1 = write, 0 = read), then DATA_W data bits (bits 33..64), then 8 checksum bits (bits 72:65). A valid write frame gives one bus cycle with that address and data, `bus_we_o`=1, `bus_sel_o` all ones and `bus_cab_o`=0.
- R3: The checksum is computed over the first ADDR_W+1+DATA_W shifted bits in shift order. It starts at 0 and is updated per bit as fb = crc[7] xor bit, crc = (crc << 1) xor (fb ? 8'h07 : 0). A frame whose received checksum differs starts no bus cycle.
- R4: A frame is only accepted when exactly ADDR_W+1+DATA_W+8 bits were shifted since the last capture. Shorter or longer frames start no bus cycle.
- R5: A read frame gives a bus cycle with `bus_we_o`=0 and `bus_dat_o`=0, so the shifted data bits are ignored. The word taken with `bus_ack_i` appears on `tdo` during the next scan as bits 0..DATA_W-1, LSB first.
- R6: `bus_cyc_o` and `bus_stb_o` stay high, with address and direction held, until `bus_ack_i` or `bus_err_i`. They drop in the cycle after it.
- R7: Scan bit DATA_W (bit 32) is 1 when the last completed access ended with `bus_err_i`, and 0 after one ended with `bus_ack_i`. An errored read leaves the held read word unchanged.
- R8: A frame that updates while an earlier access is still unfinished is dropped.
- R9: A write access leaves the held read word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| trst_n | input | 1 | Scan-side reset, active low, asynchronous |
| capture_dr | input | 1 | TAP capture state; loads the returned word and status |
| shift_dr | input | 1 | TAP shift state; moves one frame bit per tck |
| update_dr | input | 1 | TAP update state; checks and issues the frame |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, the shift register's low bit |
| sys_clk | input | 1 | System bus clock |
| sys_rst_n | input | 1 | System-side reset, active low, asynchronous |
| bus_cyc_o | output | 1 | Bus cycle valid |
| bus_stb_o | output | 1 | Bus strobe |
| bus_we_o | output | 1 | Bus write enable |
| bus_sel_o | output | DATA_W/8 | Byte selects, all ones during a cycle |
| bus_cab_o | output | 1 | Burst hint, always 0 |
| bus_adr_o | output | ADDR_W | Bus address |
| bus_dat_o | output | DATA_W | Write data, 0 on reads |
| bus_dat_i | input | DATA_W | Read data from the slave |
| bus_ack_i | input | 1 | Slave acknowledge |
| bus_err_i | input | 1 | Slave error |

## Verification
The bench uses the default ADDR_W=32 and DATA_W=32, which gives the full-width 73-bit frame with its checksum at bits 72:65. With these values, frames of 72 and 74 bits sit right next to the legal length. A slave model with adjustable latency, error injection and a hold switch makes it possible to test a long-held cycle, an errored read and a frame that arrives while an access is still unfinished.

// File: rtl/jbb_pkg.sv
`timescale 1ns/1ps
package jbb_pkg;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  // one serial checksum step, MSB-side feedback
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/jbb_rst_sync.sv
`timescale 1ns/1ps
module jbb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end
  assign rst_n = stage[1];
endmodule

// File: rtl/jbb_sync2.sv
`timescale 1ns/1ps
module jbb_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/jbb_scan_frame.sv
`timescale 1ns/1ps
module jbb_scan_frame #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic [DATA_W:0]   cap_word,
  output logic              tdo,
  output logic              len_ok,
  output logic              crc_ok,
  output logic              hit,
  output logic [ADDR_W-1:0] f_addr,
  output logic              f_we,
  output logic [DATA_W-1:0] f_data
);
  import jbb_pkg::*;
  localparam int PAY = ADDR_W + 1 + DATA_W;
  localparam int FL  = PAY + CRC_W;
  localparam int CW  = $clog2(FL + 2);
  localparam logic [CW-1:0] PAY_C = CW'(PAY);
  localparam logic [CW-1:0] FL_C  = CW'(FL);
  localparam logic [CW-1:0] SAT_C = CW'(FL + 1);

  logic [FL-1:0]    sr_q, sr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    crc_d = crc_q;
    if (capture_dr) begin
      sr_d  = {{(FL-DATA_W-1){1'b0}}, cap_word};
      cnt_d = '0;
      crc_d = '0;
    end else if (shift_dr) begin
      sr_d = {tdi, sr_q[FL-1:1]};
      if (cnt_q != SAT_C) cnt_d = cnt_q + CW'(1);
      if (cnt_q < PAY_C)  crc_d = crc_step(crc_q, tdi);
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      crc_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      crc_q <= crc_d;
    end
  end

  assign tdo    = sr_q[0];
  assign len_ok = (cnt_q == FL_C);
  assign crc_ok = (sr_q[FL-1 -: CRC_W] == crc_q);
  assign hit    = update_dr & len_ok & crc_ok;
  assign f_addr = sr_q[ADDR_W-1:0];
  assign f_we   = sr_q[ADDR_W];
  assign f_data = sr_q[ADDR_W+1 +: DATA_W];
endmodule

// File: rtl/jbb_bus_master.sv
`timescale 1ns/1ps
module jbb_bus_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_tgl_s,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic                in_we,
  input  logic [DATA_W-1:0]   in_data,
  output logic                cyc,
  output logic                stb,
  output logic                we,
  output logic [DATA_W/8-1:0] sel,
  output logic                cab,
  output logic [ADDR_W-1:0]   adr,
  output logic [DATA_W-1:0]   dat_o,
  input  logic [DATA_W-1:0]   dat_i,
  input  logic                ack,
  input  logic                err,
  output logic                done_tgl,
  output logic [DATA_W-1:0]   rd_word,
  output logic                err_flag
);
  logic              seen_q, seen_d;
  logic              cyc_q, cyc_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              er_q, er_d;
  logic              start, finish;

  assign start  = (req_tgl_s != seen_q) && !cyc_q;
  assign finish = cyc_q && (ack || err);

  always_comb begin
    seen_d = seen_q;
    cyc_d  = cyc_q;
    we_d   = we_q;
    adr_d  = adr_q;
    dat_d  = dat_q;
    done_d = done_q;
    rd_d   = rd_q;
    er_d   = er_q;
    if (start) begin
      seen_d = req_tgl_s;
      cyc_d  = 1'b1;
      we_d   = in_we;
      adr_d  = in_addr;
      dat_d  = in_we ? in_data : '0;
    end
    if (finish) begin
      cyc_d  = 1'b0;
      done_d = ~done_q;
      if (err) begin
        er_d = 1'b1;
      end else begin
        er_d = 1'b0;
        if (!we_q) rd_d = dat_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cyc_q  <= 1'b0;
      we_q   <= 1'b0;
      adr_q  <= '0;
      dat_q  <= '0;
      done_q <= 1'b0;
      rd_q   <= '0;
      er_q   <= 1'b0;
    end else begin
      seen_q <= seen_d;
      cyc_q  <= cyc_d;
      we_q   <= we_d;
      adr_q  <= adr_d;
      dat_q  <= dat_d;
      done_q <= done_d;
      rd_q   <= rd_d;
      er_q   <= er_d;
    end
  end

  assign cyc      = cyc_q;
  assign stb      = cyc_q;
  assign we       = we_q;
  assign sel      = '1;
  assign cab      = 1'b0;
  assign adr      = adr_q;
  assign dat_o    = dat_q;
  assign done_tgl = done_q;
  assign rd_word  = rd_q;
  assign err_flag = er_q;
endmodule

// File: rtl/jtag_bus_bridge.sv
`timescale 1ns/1ps
module jtag_bus_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                tdi,
  output logic                tdo,
  input  logic                sys_clk,
  input  logic                sys_rst_n,
  output logic                bus_cyc_o,
  output logic                bus_stb_o,
  output logic                bus_we_o,
  output logic [DATA_W/8-1:0] bus_sel_o,
  output logic                bus_cab_o,
  output logic [ADDR_W-1:0]   bus_adr_o,
  output logic [DATA_W-1:0]   bus_dat_o,
  input  logic [DATA_W-1:0]   bus_dat_i,
  input  logic                bus_ack_i,
  input  logic                bus_err_i
);
  logic tck_rst_n, sys_rst_s;

  jbb_rst_sync u_rst_tck (.clk(tck),     .arst_n(trst_n),    .rst_n(tck_rst_n));
  jbb_rst_sync u_rst_sys (.clk(sys_clk), .arst_n(sys_rst_n), .rst_n(sys_rst_s));

  // scan-clock side
  logic              len_ok, crc_ok, hit, f_we;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;
  logic              req_tgl, req_d;
  logic [ADDR_W-1:0] h_addr, h_addr_d;
  logic              h_we, h_we_d;
  logic [DATA_W-1:0] h_data, h_data_d;
  logic              done_sync, done_seen;
  logic [DATA_W-1:0] rd_tck, rd_tck_d;
  logic              err_tck, err_tck_d;
  logic              busy, accept;

  // sys side
  logic              req_sync, done_tgl, err_sys;
  logic [DATA_W-1:0] rd_sys;

  jbb_scan_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .tck(tck), .rst_n(tck_rst_n),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi),
    .cap_word({err_tck, rd_tck}), .tdo(tdo),
    .len_ok(len_ok), .crc_ok(crc_ok), .hit(hit),
    .f_addr(f_addr), .f_we(f_we), .f_data(f_data)
  );

  assign busy   = (req_tgl != done_seen);
  assign accept = hit & ~busy;

  always_comb begin
    req_d     = req_tgl;
    h_addr_d  = h_addr;
    h_we_d    = h_we;
    h_data_d  = h_data;
    rd_tck_d  = rd_tck;
    err_tck_d = err_tck;
    if (accept) begin
      req_d    = ~req_tgl;
      h_addr_d = f_addr;
      h_we_d   = f_we;
      h_data_d = f_data;
    end
    if (done_sync != done_seen) begin
      rd_tck_d  = rd_sys;
      err_tck_d = err_sys;
    end
  end

  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n) begin
      req_tgl   <= 1'b0;
      h_addr    <= '0;
      h_we      <= 1'b0;
      h_data    <= '0;
      done_seen <= 1'b0;
      rd_tck    <= '0;
      err_tck   <= 1'b0;
    end else begin
      req_tgl   <= req_d;
      h_addr    <= h_addr_d;
      h_we      <= h_we_d;
      h_data    <= h_data_d;
      done_seen <= done_sync;
      rd_tck    <= rd_tck_d;
      err_tck   <= err_tck_d;
    end
  end

  jbb_sync2 u_done_sync (.clk(tck),     .rst_n(tck_rst_n), .d(done_tgl), .q(done_sync));
  jbb_sync2 u_req_sync  (.clk(sys_clk), .rst_n(sys_rst_s), .d(req_tgl),  .q(req_sync));

  jbb_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
    .clk(sys_clk), .rst_n(sys_rst_s), .req_tgl_s(req_sync),
    .in_addr(h_addr), .in_we(h_we), .in_data(h_data),
    .cyc(bus_cyc_o), .stb(bus_stb_o), .we(bus_we_o), .sel(bus_sel_o), .cab(bus_cab_o),
    .adr(bus_adr_o), .dat_o(bus_dat_o), .dat_i(bus_dat_i),
    .ack(bus_ack_i), .err(bus_err_i),
    .done_tgl(done_tgl), .rd_word(rd_sys), .err_flag(err_sys)
  );
endmodule

// File: rtl/jbb_checker.sv
`timescale 1ns/1ps
module jbb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              tck,
  input logic              tck_rst_n,
  input logic              update_dr,
  input logic              busy,
  input logic              crc_ok,
  input logic              len_ok,
  input logic              req_tgl,
  input logic              sys_clk,
  input logic              sys_rst_s,
  input logic              cyc,
  input logic              ack,
  input logic              err,
  input logic              we,
  input logic [ADDR_W-1:0] adr
);
  AST_BAD_CRC_DROPS: assert property (@(posedge tck) disable iff (!tck_rst_n)
    update_dr && !crc_ok |=> $stable(req_tgl)); // R3
  AST_BAD_LEN_DROPS: assert property (@(posedge tck) disable iff (!tck_rst_n)
    update_dr && !len_ok |=> $stable(req_tgl)); // R4
  AST_BUSY_DROPS: assert property (@(posedge tck) disable iff (!tck_rst_n)
    update_dr && busy |=> $stable(req_tgl)); // R8
  AST_HOLD_UNTIL_DONE: assert property (@(posedge sys_clk) disable iff (!sys_rst_s)
    cyc && !ack && !err |=> cyc && $stable(adr) && $stable(we)); // R6
  AST_DROP_AFTER_DONE: assert property (@(posedge sys_clk) disable iff (!sys_rst_s)
    cyc && (ack || err) |=> !cyc); // R6
endmodule

bind jtag_bus_bridge jbb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .tck(tck), .tck_rst_n(tck_rst_n), .update_dr(update_dr), .busy(busy),
  .crc_ok(crc_ok), .len_ok(len_ok), .req_tgl(req_tgl),
  .sys_clk(sys_clk), .sys_rst_s(sys_rst_s), .cyc(bus_cyc_o),
  .ack(bus_ack_i), .err(bus_err_i), .we(bus_we_o), .adr(bus_adr_o)
);

// File: tb/sim_jtag_bus_bridge.sv
`timescale 1ns/1ps
module sim_jtag_bus_bridge;
  logic tck, trst_n, capture_dr, shift_dr, update_dr, tdi, tdo;
  logic sys_clk, sys_rst_n;
  logic bus_cyc_o, bus_stb_o, bus_we_o, bus_cab_o, bus_ack_i, bus_err_i;
  logic [3:0]  bus_sel_o;
  logic [31:0] bus_adr_o, bus_dat_o, bus_dat_i;

  jtag_bus_bridge u0 (
    .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .bus_cyc_o(bus_cyc_o), .bus_stb_o(bus_stb_o), .bus_we_o(bus_we_o), .bus_sel_o(bus_sel_o),
    .bus_cab_o(bus_cab_o), .bus_adr_o(bus_adr_o), .bus_dat_o(bus_dat_o), .bus_dat_i(bus_dat_i),
    .bus_ack_i(bus_ack_i), .bus_err_i(bus_err_i)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // slave model state
  int lat = 3;
  bit err_mode = 0;
  bit hold = 0;
  logic [31:0] slave_word = 32'h0;
  int n_cyc = 0;
  int cyc_len = 0;
  int wcnt = 0;
  bit prev_cyc = 0;
  logic [31:0] l_adr, l_dat;
  logic l_we, l_cab;
  logic [3:0] l_sel;

  // 250 MHz, rising edges on odd ns
  initial begin
    sys_clk = 0;
    #1;
    forever begin sys_clk = 1; #2; sys_clk = 0; #2; end
  end

  initial begin
    bus_ack_i = 0; bus_err_i = 0; bus_dat_i = 0;
    forever begin
      @(posedge sys_clk); #1;
      if (bus_cyc_o && !prev_cyc) begin
        n_cyc++; l_adr = bus_adr_o; l_dat = bus_dat_o; l_we = bus_we_o;
        l_sel = bus_sel_o; l_cab = bus_cab_o; cyc_len = 0; wcnt = 0;
      end
      if (bus_cyc_o) cyc_len++;
      prev_cyc = bus_cyc_o;
      if (bus_ack_i || bus_err_i) begin
        bus_ack_i = 0; bus_err_i = 0;
      end else if (bus_cyc_o && bus_stb_o && !hold) begin
        if (wcnt >= lat) begin
          if (err_mode) bus_err_i = 1;
          else begin bus_ack_i = 1; bus_dat_i = slave_word; end
        end else wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tck_pulse();
    #10 tck = 1;
    #10 tck = 0;
  endtask

  function automatic logic [7:0] ref_crc(input logic [64:0] p);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 65; i++) begin
      logic fb = c[7] ^ p[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic logic [79:0] mk(input logic [31:0] a, input bit w, input logic [31:0] d);
    logic [64:0] p = {d, w, a};
    return {7'b0, ref_crc(p), p};
  endfunction

  // capture, shift n bits, optional update, then idle clocks
  task automatic scan(input logic [79:0] v, input int n, input bit upd, output logic [79:0] got);
    got = '0;
    capture_dr = 1; tck_pulse(); capture_dr = 0;
    shift_dr = 1;
    for (int i = 0; i < n; i++) begin
      tdi = v[i];
      got[i] = tdo;
      tck_pulse();
    end
    shift_dr = 0; tdi = 0;
    if (upd) begin update_dr = 1; tck_pulse(); update_dr = 0; end
    repeat (8) tck_pulse();
  endtask

  task automatic t_reset();
    chk(bus_cyc_o == 0 && bus_stb_o == 0, "R1 idle bus after reset", {62'b0, bus_cyc_o, bus_stb_o}, 0);
    chk(tdo == 0, "R1 tdo after reset", tdo, 0);
  endtask

  task automatic t_write();
    logic [79:0] g;
    int n0 = n_cyc;
    scan(mk(32'h1827_3645, 1, 32'hBEEF_0123), 73, 1, g);
    chk(n_cyc == n0 + 1, "R2 one write cycle", n_cyc - n0, 1);
    chk(l_adr == 32'h1827_3645, "R2 write address", l_adr, 32'h1827_3645);
    chk(l_dat == 32'hBEEF_0123, "R2 write data", l_dat, 32'hBEEF_0123);
    chk(l_we == 1 && l_sel == 4'hF && l_cab == 0, "R2 we/sel/cab", {l_we, l_sel, l_cab}, {1'b1, 4'hF, 1'b0});
  endtask

  task automatic t_read();
    logic [79:0] g;
    int n0 = n_cyc;
    slave_word = 32'hBEEF_DEAD;
    scan(mk(32'h8765_4321, 0, 32'h5555_AAAA), 73, 1, g);
    chk(n_cyc == n0 + 1 && l_we == 0, "R5 read cycle", {l_we, 32'(n_cyc - n0)}, 1);
    chk(l_dat == 0, "R5 read data bits ignored", l_dat, 0);
    scan('0, 73, 0, g);
    chk(g[31:0] == 32'hBEEF_DEAD, "R5 read word next scan", g[31:0], 32'hBEEF_DEAD);
    chk(g[32] == 0, "R7 no error flag", g[32], 0);
  endtask

  task automatic t_write_keeps();
    logic [79:0] g;
    slave_word = 32'h1111_2222;
    scan(mk(32'h0000_0040, 1, 32'h9999_9999), 73, 1, g);
    scan('0, 73, 0, g);
    chk(g[31:0] == 32'hBEEF_DEAD, "R9 write keeps read word", g[31:0], 32'hBEEF_DEAD);
  endtask

  task automatic t_bad_crc();
    logic [79:0] g, f;
    int n0 = n_cyc;
    f = mk(32'hCAFE_0000, 1, 32'h1);
    f[70] = ~f[70];
    scan(f, 73, 1, g);
    chk(n_cyc == n0, "R3 bad checksum dropped", n_cyc - n0, 0);
    f = mk(32'hCAFE_0000, 1, 32'h1);
    f[5] = ~f[5];
    scan(f, 73, 1, g);
    chk(n_cyc == n0, "R3 corrupted payload dropped", n_cyc - n0, 0);
  endtask

  task automatic t_length();
    logic [79:0] g;
    int n0 = n_cyc;
    scan(mk(32'h0000_0100, 1, 32'h2), 72, 1, g);
    chk(n_cyc == n0, "R4 short frame dropped", n_cyc - n0, 0);
    scan({mk(32'h0000_0100, 1, 32'h2)} << 1, 74, 1, g);
    chk(n_cyc == n0, "R4 long frame dropped", n_cyc - n0, 0);
  endtask

  task automatic t_error();
    logic [79:0] g;
    err_mode = 1;
    slave_word = 32'h7777_7777;
    scan(mk(32'h0000_0200, 0, 32'h0), 73, 1, g);
    err_mode = 0;
    scan('0, 73, 0, g);
    chk(g[32] == 1, "R7 error flag set", g[32], 1);
    chk(g[31:0] == 32'hBEEF_DEAD, "R7 errored read keeps word", g[31:0], 32'hBEEF_DEAD);
    scan(mk(32'h0000_0204, 1, 32'h3), 73, 1, g);
    scan('0, 73, 0, g);
    chk(g[32] == 0, "R7 error flag cleared by ack", g[32], 0);
  endtask

  task automatic t_busy();
    logic [79:0] g;
    int n0 = n_cyc;
    hold = 1;
    scan(mk(32'hAAAA_0001, 1, 32'h10), 73, 1, g);
    scan(mk(32'hBBBB_0002, 1, 32'h20), 73, 1, g);
    chk(bus_cyc_o == 1 && bus_adr_o == 32'hAAAA_0001, "R6 cycle held without ack", bus_adr_o, 32'hAAAA_0001);
    hold = 0;
    repeat (10) tck_pulse();
    chk(n_cyc == n0 + 1 && l_adr == 32'hAAAA_0001, "R8 second frame dropped", n_cyc - n0, 1);
    scan(mk(32'hCCCC_0003, 1, 32'h30), 73, 1, g);
    chk(n_cyc == n0 + 2 && l_adr == 32'hCCCC_0003, "R8 accepted after finish", l_adr, 32'hCCCC_0003);
  endtask

  task automatic t_latency();
    logic [79:0] g;
    lat = 12;
    scan(mk(32'h0000_0300, 1, 32'h4), 73, 1, g);
    chk(cyc_len >= 12, "R6 cycle spans slave latency", cyc_len, 12);
    lat = 3;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tck = 0; trst_n = 0; sys_rst_n = 0;
    capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
    repeat (3) tck_pulse();
    trst_n = 1; sys_rst_n = 1;
    repeat (4) tck_pulse();
    t_reset();
    t_write();
    t_read();
    t_write_keeps();
    t_bad_crc();
    t_length();
    t_error();
    t_busy();
    t_latency();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule